// File: doc/BRIEF.md
# Masked Calendar Alarm with Repeat Counter

This block watches a running calendar clock, delivered as packed BCD digits, and compares it against a stored alarm time. A 4-bit interval code chooses how many of the clock's digits must agree with the alarm value. The choices range from matching on every half-second tick, with no digit compared at all, up to a yearly match on month, day, hours, minutes and seconds. Matching is evaluated only in the cycle that carries the half-second tick. Each qualifying tick gives exactly one event. The event raises a one-cycle interrupt in the following cycle. The block does not count time itself. It only observes the time fields.

An 8-bit repeat counter sets how many more events the alarm may raise. The counter steps down on every event. When an event arrives with the counter already at zero, the enable drops after that final event. Chime mode changes this: the counter wraps from zero to all ones and the enable stays on, so the alarm repeats without end. A configuration load strobe writes the enable and the counter. A reset clears both. A shared output pin carries one of two signals: a toggle that flips on every event (a 50% clock at half the event rate), or the seconds clock. An output-enable bit gates the pin.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset, `alarmEn` is 0, `repeatCnt` is 0, `irq` is 0, and the event toggle is 0 (so `pinOut` is 0 with `pinSel`=0).
- R2: The time and alarm buses share one layout: seconds ones [3:0], seconds tens [6:4], minutes ones [10:7], minutes tens [13:11], hours ones [17:14], hours tens [19:18], weekday [22:20], day ones [26:23], day tens [28:27], month ones [32:29], month tens [33]. The digits that must match grow with the code: 2 = seconds ones; 3 = both seconds digits; 4 = adds minutes ones; 5 = all minutes and seconds; 6 = adds hours; 7 = adds weekday.
- R3: Code 8 compares day, hours, minutes and seconds, and ignores month and weekday. Code 9 also compares the month. A code-9 alarm set to 02/29 fires only when the clock shows 02/29.
- R4: Code 0 qualifies on every tick. Every other code qualifies only on ticks where `halfPhase` is 0 (the start of a whole second).
- R5: Codes 10 to 15 never produce an event.
- R6: An event needs `tickHalf`=1, `alarmEn`=1, a qualifying code and a digit match in the same cycle. `irq` is high for exactly the next cycle.
- R7: Each event decrements `repeatCnt` by one when it is nonzero. The enable stays set.
- R8: An event with `repeatCnt`=0 and `chime`=0 is the last one. `alarmEn` reads 0 from the next cycle on, and later matches raise nothing.
- R9: An event with `repeatCnt`=0 and `chime`=1 sets `repeatCnt` to 255 and keeps `alarmEn` at 1.
- R10: The event toggle flips on every event and on nothing else.
- R11: `pinOut` is 0 when `outEn`=0. Otherwise it is the event toggle when `pinSel`=0, and `halfPhase` (the seconds clock) when `pinSel`=1. `pinDrive` equals `outEn`.
- R12: `cfgLoad` writes `alarmEn` and `repeatCnt` from `cfgEnable` and `cfgCount`. It overrides an event in the same cycle, which is then dropped (no `irq`, no toggle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; clears alarm configuration |
| tickHalf | input | 1 | One-cycle strobe; time inputs already show the new half second |
| halfPhase | input | 1 | 0 in first half of the second, 1 in second half |
| timeNow | input | 34 | Current BCD time and date, layout per R2 |
| alarmVal | input | 34 | Alarm BCD value, same layout |
| maskCode | input | 4 | Match interval code |
| chime | input | 1 | Endless repeat mode |
| cfgLoad | input | 1 | Load strobe for enable and counter |
| cfgEnable | input | 1 | Enable value to load |
| cfgCount | input | 8 | Repeat count value to load |
| pinSel | input | 1 | Pin source: 0 event toggle, 1 seconds clock |
| outEn | input | 1 | Pin output enable |
| alarmEn | output | 1 | Current alarm enable |
| repeatCnt | output | 8 | Current repeat counter |
| irq | output | 1 | One-cycle alarm interrupt |
| pinOut | output | 1 | Pin value |
| pinDrive | output | 1 | Pin drive enable |

## Verification
A wrong digit mask or a wrong phase qualifier shows up one cycle after the tick, as a missing or extra `irq` pulse. The same error also shows as a `repeatCnt` that is off by one from that cycle onward. A fault in the counter or the auto-disable logic stays visible on `alarmEn` and `repeatCnt` until the next load, so the per-clock model comparison catches it within one cycle. A toggle that stops following the events shows on `pinOut`, and it stays wrong for every later cycle with `pinSel`=0.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int TIME_W = 34;

  // Digit positions within the packed BCD time bus
  localparam int SEC_ONES_HI = 3;
  localparam int SEC_HI      = 6;
  localparam int MIN_ONES_HI = 10;
  localparam int MIN_HI      = 13;
  localparam int HR_HI       = 19;
  localparam int WDAY_HI     = 22;
  localparam int DAY_LO      = 23;
  localparam int DAY_HI      = 28;
  localparam int MON_HI      = 33;

  localparam logic [3:0] CODE_MAX = 4'd9;

  typedef struct packed {
    logic fire;     // qualified alarm event this cycle
    logic stepCnt;  // counter decrements (or wraps under chime)
    logic dropEn;   // final event: enable clears
  } alarmStrobes_t;

  function automatic logic [TIME_W-1:0] lowOnes(input int hi);
    logic [TIME_W-1:0] m;
    for (int i = 0; i < TIME_W; i++) m[i] = (i <= hi);
    return m;
  endfunction

  function automatic logic [TIME_W-1:0] rangeOnes(input int lo, input int hi);
    logic [TIME_W-1:0] m;
    for (int i = 0; i < TIME_W; i++) m[i] = (i >= lo) && (i <= hi);
    return m;
  endfunction

  // Bits that must agree for each interval code
  function automatic logic [TIME_W-1:0] digitMask(input logic [3:0] code);
    case (code)
      4'd2:    return lowOnes(SEC_ONES_HI);
      4'd3:    return lowOnes(SEC_HI);
      4'd4:    return lowOnes(MIN_ONES_HI);
      4'd5:    return lowOnes(MIN_HI);
      4'd6:    return lowOnes(HR_HI);
      4'd7:    return lowOnes(WDAY_HI);
      4'd8:    return lowOnes(HR_HI) | rangeOnes(DAY_LO, DAY_HI);
      4'd9:    return lowOnes(HR_HI) | rangeOnes(DAY_LO, MON_HI);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/alarm_match_dp.sv
module alarm_match_dp
  import alarm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [TIME_W-1:0]   timeNow,
  input  logic [TIME_W-1:0]   alarmVal,
  input  logic [3:0]          maskCode,
  input  alarmStrobes_t       strobes,
  input  logic                cfgLoad,
  input  logic [CNT_W-1:0]    cfgCount,
  output logic                hit,
  output logic                cntZero,
  output logic [CNT_W-1:0]    repeatCnt,
  output logic                pulse
);
  logic [TIME_W-1:0] careBits;
  logic [TIME_W-1:0] bitOk;

  assign careBits = digitMask(maskCode);

  genvar g;
  generate
    for (g = 0; g < TIME_W; g++) begin : g_cmp
      assign bitOk[g] = ~careBits[g] | (timeNow[g] ~^ alarmVal[g]);
    end
  endgenerate

  assign hit     = &bitOk;
  assign cntZero = (repeatCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      repeatCnt <= '0;
      pulse     <= 1'b0;
    end else begin
      if (cfgLoad)              repeatCnt <= cfgCount;
      else if (strobes.stepCnt) repeatCnt <= repeatCnt - 1'b1;
      if (strobes.fire)         pulse     <= ~pulse;
    end
  end
endmodule

// File: rtl/alarm_match_ctrl.sv
module alarm_match_ctrl
  import alarm_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickHalf,
  input  logic          halfPhase,
  input  logic [3:0]    maskCode,
  input  logic          hit,
  input  logic          cntZero,
  input  logic          chime,
  input  logic          cfgLoad,
  input  logic          cfgEnable,
  output logic          alarmEn,
  output logic          irq,
  output alarmStrobes_t strobes
);
  logic codeOk;
  logic phaseOk;
  logic qualify;

  assign codeOk  = (maskCode <= CODE_MAX);
  assign phaseOk = (maskCode == 4'd0) || !halfPhase;
  assign qualify = tickHalf && alarmEn && codeOk && phaseOk && hit && !cfgLoad;

  always_comb begin
    strobes.fire    = qualify;
    strobes.stepCnt = qualify && (!cntZero || chime);
    strobes.dropEn  = qualify && cntZero && !chime;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmEn <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= strobes.fire;
      if (cfgLoad)             alarmEn <= cfgEnable;
      else if (strobes.dropEn) alarmEn <= 1'b0;
    end
  end
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickHalf,
  input  logic              halfPhase,
  input  logic [TIME_W-1:0] timeNow,
  input  logic [TIME_W-1:0] alarmVal,
  input  logic [3:0]        maskCode,
  input  logic              chime,
  input  logic              cfgLoad,
  input  logic              cfgEnable,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic              pinSel,
  input  logic              outEn,
  output logic              alarmEn,
  output logic [CNT_W-1:0]  repeatCnt,
  output logic              irq,
  output logic              pinOut,
  output logic              pinDrive
);
  alarmStrobes_t strobes;
  logic hit;
  logic cntZero;
  logic pulse;

  alarm_match_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .tickHalf(tickHalf), .halfPhase(halfPhase),
    .maskCode(maskCode), .hit(hit), .cntZero(cntZero), .chime(chime),
    .cfgLoad(cfgLoad), .cfgEnable(cfgEnable),
    .alarmEn(alarmEn), .irq(irq), .strobes(strobes)
  );

  alarm_match_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .timeNow(timeNow), .alarmVal(alarmVal),
    .maskCode(maskCode), .strobes(strobes), .cfgLoad(cfgLoad),
    .cfgCount(cfgCount), .hit(hit), .cntZero(cntZero),
    .repeatCnt(repeatCnt), .pulse(pulse)
  );

  assign pinDrive = outEn;
  assign pinOut   = outEn && (pinSel ? halfPhase : pulse);
endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickHalf,
  input logic [3:0]       maskCode,
  input logic             chime,
  input logic             cfgLoad,
  input logic             alarmEn,
  input logic [CNT_W-1:0] repeatCnt,
  input logic             irq,
  input logic             pulse
);
  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ($past(tickHalf) && $past(alarmEn) && !$past(cfgLoad))); // R6

  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ($past(maskCode) <= 4'd9)); // R5

  AST_TOGGLE_ON_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (pulse != $past(pulse))); // R10

  AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !irq |-> $stable(pulse)); // R10

  AST_AUTO_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $fell(alarmEn) |-> ($past(cfgLoad) ||
                        (irq && ($past(repeatCnt) == '0) && !$past(chime)))); // R8

  AST_CHIME_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (irq && $past(chime) && ($past(repeatCnt) == '0)) |->
      ((repeatCnt == '1) && alarmEn)); // R9
endmodule

bind alarm_match_unit alarm_match_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .tickHalf(tickHalf), .maskCode(maskCode),
  .chime(chime), .cfgLoad(cfgLoad), .alarmEn(alarmEn),
  .repeatCnt(repeatCnt), .irq(irq), .pulse(pulse)
);

// File: tb/alarm_match_unit_tb.sv
`timescale 1ns/1ps
module alarm_match_unit_tb_top;
  localparam real CYC = 5.0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickHalf = 1'b0, halfPhase = 1'b0;
  logic [33:0] timeNow = '0, alarmVal = '0;
  logic [3:0] maskCode = 4'd3;
  logic chime = 1'b0, cfgLoad = 1'b0, cfgEnable = 1'b0;
  logic [7:0] cfgCount = '0;
  logic pinSel = 1'b0, outEn = 1'b1;
  logic alarmEn, irq, pinOut, pinDrive;
  logic [7:0] repeatCnt;

  int tests = 0, fails = 0;
  bit done = 0;

  always #(CYC/2) clk = ~clk;

  alarm_match_unit dut_i (
    .clk(clk), .rstN(rstN), .tickHalf(tickHalf), .halfPhase(halfPhase),
    .timeNow(timeNow), .alarmVal(alarmVal), .maskCode(maskCode),
    .chime(chime), .cfgLoad(cfgLoad), .cfgEnable(cfgEnable),
    .cfgCount(cfgCount), .pinSel(pinSel), .outEn(outEn),
    .alarmEn(alarmEn), .repeatCnt(repeatCnt), .irq(irq),
    .pinOut(pinOut), .pinDrive(pinDrive)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [33:0] pk(input int mon, input int day, input int wd,
                                     input int hr, input int mi, input int se);
    return {1'(mon / 10), 4'(mon % 10), 2'(day / 10), 4'(day % 10), 3'(wd),
            2'(hr / 10), 4'(hr % 10), 3'(mi / 10), 4'(mi % 10),
            3'(se / 10), 4'(se % 10)};
  endfunction

  function automatic int fld(input logic [33:0] b, input int lo, input int w);
    return int'((b >> lo) & ((34'd1 << w) - 1));
  endfunction

  // Behavioural match per R2..R5
  function automatic bit modelMatch(input logic [3:0] code, input bit ph,
                                    input logic [33:0] t, input logic [33:0] a);
    bit so, se, mo, mi, hr, wd, dy, mn;
    so = fld(t, 0, 4) == fld(a, 0, 4);
    se = so && fld(t, 4, 3) == fld(a, 4, 3);
    mo = fld(t, 7, 4) == fld(a, 7, 4);
    mi = mo && fld(t, 11, 3) == fld(a, 11, 3);
    hr = fld(t, 14, 6) == fld(a, 14, 6);
    wd = fld(t, 20, 3) == fld(a, 20, 3);
    dy = fld(t, 23, 6) == fld(a, 23, 6);
    mn = fld(t, 29, 5) == fld(a, 29, 5);
    if (code == 0) return 1;
    if (ph) return 0;
    case (code)
      1: return 1;
      2: return so;
      3: return se;
      4: return se && mo;
      5: return se && mi;
      6: return se && mi && hr;
      7: return se && mi && hr && wd;
      8: return se && mi && hr && dy;
      9: return se && mi && hr && dy && mn;
      default: return 0;
    endcase
  endfunction

  // Reference model, compared on every clock
  bit mEn = 0, mIrq = 0, mPulse = 0;
  int mCnt = 0;
  always @(posedge clk) begin
    bit fire;
    if (!rstN) begin
      mEn = 0; mIrq = 0; mPulse = 0; mCnt = 0;
    end else begin
      fire = tickHalf && mEn && !cfgLoad && modelMatch(maskCode, halfPhase, timeNow, alarmVal);
      mIrq = fire;
      if (cfgLoad) begin
        mEn = cfgEnable; mCnt = int'(cfgCount);
      end else if (fire) begin
        if (mCnt == 0 && !chime) mEn = 0;
        else mCnt = (mCnt + 255) % 256;
      end
      if (fire) mPulse = !mPulse;
    end
    #1;
    if (rstN && !done) begin
      chk("R6 irq", int'(irq), int'(mIrq));
      chk("R7 repeatCnt", int'(repeatCnt), mCnt);
      chk("R8 alarmEn", int'(alarmEn), int'(mEn));
      chk("R11 pinOut", int'(pinOut), outEn ? (pinSel ? int'(halfPhase) : int'(mPulse)) : 0);
      chk("R11 pinDrive", int'(pinDrive), int'(outEn));
    end
  end

  task automatic tick(input logic [33:0] t, input bit ph);
    @(negedge clk); timeNow = t; halfPhase = ph; tickHalf = 1;
    @(negedge clk); tickHalf = 0;
  endtask

  task automatic load(input bit en, input int cnt);
    @(negedge clk); cfgLoad = 1; cfgEnable = en; cfgCount = 8'(cnt);
    @(negedge clk); cfgLoad = 0;
  endtask

  initial begin
    #(CYC * 200000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [33:0] aStd;
    aStd = pk(3, 15, 2, 10, 20, 30);
    alarmVal = aStd;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 enable", int'(alarmEn), 0);
    chk("R1 count", int'(repeatCnt), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 pin", int'(pinOut), 0);

    // every minute: minutes ignored, phase 1 ignored
    maskCode = 4'd3; load(1, 2);
    tick(pk(1, 1, 0, 0, 0, 29), 0); chk("R2 sec mismatch", int'(irq), 0);
    tick(pk(1, 1, 0, 0, 0, 30), 1); chk("R4 phase1", int'(irq), 0);
    tick(pk(1, 1, 0, 0, 5, 30), 0); chk("R2 minute match", int'(irq), 1);
    chk("R7 dec", int'(repeatCnt), 1);
    chk("R10 toggle", int'(pinOut), 1);

    maskCode = 4'd2; load(1, 20);
    tick(pk(1, 1, 0, 0, 0, 41), 0); chk("R2 ones off", int'(irq), 0);
    tick(pk(1, 1, 0, 0, 0, 40), 0); chk("R2 ones only", int'(irq), 1);
    maskCode = 4'd4;
    tick(pk(1, 1, 0, 0, 11, 30), 0); chk("R2 min ones off", int'(irq), 0);
    tick(pk(1, 1, 0, 0, 50, 30), 0); chk("R2 min ones", int'(irq), 1);
    maskCode = 4'd5;
    tick(pk(1, 1, 0, 0, 21, 30), 0); chk("R2 hour code off", int'(irq), 0);
    tick(pk(1, 1, 0, 7, 20, 30), 0); chk("R2 hourly", int'(irq), 1);
    maskCode = 4'd6;
    tick(pk(1, 1, 0, 11, 20, 30), 0); chk("R2 daily off", int'(irq), 0);
    tick(pk(1, 1, 5, 10, 20, 30), 0); chk("R2 daily", int'(irq), 1);
    maskCode = 4'd7;
    tick(pk(1, 1, 3, 10, 20, 30), 0); chk("R2 weekly off", int'(irq), 0);
    tick(pk(1, 1, 2, 10, 20, 30), 0); chk("R2 weekly", int'(irq), 1);
    maskCode = 4'd8;
    tick(pk(7, 15, 6, 10, 20, 30), 0); chk("R3 monthly", int'(irq), 1);
    tick(pk(7, 16, 6, 10, 20, 30), 0); chk("R3 monthly off", int'(irq), 0);
    maskCode = 4'd9;
    tick(pk(7, 15, 2, 10, 20, 30), 0); chk("R3 yearly off", int'(irq), 0);
    tick(pk(3, 15, 2, 10, 20, 30), 0); chk("R3 yearly", int'(irq), 1);
    alarmVal = pk(2, 29, 0, 10, 20, 30);
    tick(pk(2, 28, 0, 10, 20, 30), 0); chk("R3 feb28", int'(irq), 0);
    tick(pk(2, 29, 4, 10, 20, 30), 0); chk("R3 feb29", int'(irq), 1);
    alarmVal = aStd;

    maskCode = 4'd0;
    tick(pk(1, 1, 0, 0, 0, 0), 1); chk("R4 half tick", int'(irq), 1);
    tick(pk(1, 1, 0, 0, 0, 1), 0); chk("R4 half tick", int'(irq), 1);
    maskCode = 4'd1;
    tick(pk(1, 1, 0, 0, 0, 1), 1); chk("R4 second phase1", int'(irq), 0);
    tick(pk(1, 1, 0, 0, 0, 2), 0); chk("R4 second", int'(irq), 1);

    maskCode = 4'd10;
    tick(aStd, 0); chk("R5 code10", int'(irq), 0);
    maskCode = 4'd15;
    tick(aStd, 0); chk("R5 code15", int'(irq), 0);

    maskCode = 4'd3; load(0, 5);
    tick(aStd, 0); chk("R6 disabled", int'(irq), 0);
    chk("R6 count kept", int'(repeatCnt), 5);

    load(1, 0);
    tick(aStd, 0); chk("R8 last irq", int'(irq), 1);
    chk("R8 off", int'(alarmEn), 0);
    tick(aStd, 0); chk("R8 silent", int'(irq), 0);

    chime = 1; load(1, 0);
    tick(aStd, 0); chk("R9 wrap", int'(repeatCnt), 255);
    chk("R9 stay on", int'(alarmEn), 1);
    tick(aStd, 0); chk("R7 after wrap", int'(repeatCnt), 254);
    chime = 0;

    @(negedge clk); timeNow = aStd; halfPhase = 0; tickHalf = 1;
    cfgLoad = 1; cfgEnable = 1; cfgCount = 8'd7;
    @(negedge clk); tickHalf = 0; cfgLoad = 0;
    chk("R12 no irq", int'(irq), 0);
    chk("R12 count", int'(repeatCnt), 7);

    @(negedge clk); pinSel = 1; halfPhase = 1;
    @(negedge clk); chk("R11 sec clock", int'(pinOut), 1);
    outEn = 0;
    @(negedge clk); chk("R11 gated", int'(pinOut), 0);
    chk("R11 drive", int'(pinDrive), 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule